// File: doc/BRIEF.md
# Converter Read/Convert Bus Controller

This block is the digital control side of a converter with a parallel result bus. Two active-low control inputs, a chip select and a read/convert line, are combined as levels. When both are low while the block is idle, a conversion begins. The idle flag drops and stays low for a fixed number of clock cycles. The conversion engine is stood in for by a counter. At the start it captures the supplied digital sample, and when the count runs out it moves that sample into the result register.

The result register drives the data bus through an output enable. The enable is registered from "chip select low and read/convert high". A read made while a conversion runs therefore shows the previous result. Convert requests that arrive while the block is busy are dropped.

A conversion can start in the very first idle cycle after the previous one ended, because the request was still held low. Such a conversion had no acquisition time, and it is marked with a flag. The flag holds until the next conversion starts.

Top module: `adc_bus_ctrl`

## Requirements
- R1: A conversion starts at a clock edge where the block is idle and both `csN` and `rcN` are sampled low, whichever of them fell first. `convIdle` is low in the cycle after that edge.
- R2: While `csN` is sampled high, no conversion starts, and `dataOe` is low in the following cycle.
- R3: Once started, `convIdle` stays low for exactly `CONV_CYCLES` cycles. Requests sampled during that time neither restart nor extend the conversion.
- R4: The `sample` value present at the start edge is loaded into the result register at the edge where `convIdle` returns high.
- R5: `dataOe` equals the value of (`csN` low and `rcN` high) sampled at the previous edge. `dataOut` carries the result register while `dataOe` is high and all zeros while it is low.
- R6: A read during a conversion shows the result of the previous conversion, and that value does not change until the conversion ends.
- R7: `dataOe` is low in the first busy cycle of every conversion.
- R8: A conversion that starts in the first idle cycle after another ends sets `noAcq` to 1. A conversion that starts after two or more idle cycles sets `noAcq` to 0. `noAcq` keeps its value between starts.
- R9: With `csN` held low, `dataOe` is high in every cycle that follows an edge where `rcN` was high, including during a conversion.
- R10: After reset, `convIdle` is 1, `dataOe` is 0, `dataOut` is 0 and `noAcq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rcN | input | 1 | Read (high) / convert (low) select |
| sample | input | DATA_W | Digital value the modelled conversion produces |
| dataOut | output | DATA_W | Result bus, zero when not enabled |
| dataOe | output | 1 | Bus output enable for the pad tri-state |
| convIdle | output | 1 | High when idle, low while converting |
| noAcq | output | 1 | Current or last conversion began without acquisition time |

## Verification
On every cycle, assertions check four things:
- a conversion only starts from a sampled low/low request;
- a high chip select disables the bus;
- the bus is off in the first busy cycle;
- the no-acquisition flag only rises with a start, and each busy period lasts exactly the configured length.

A held read also keeps the bus value stable throughout a conversion. Some behaviour only the bench's scenarios can show: that the right sample lands in the result register, and that the flag clears after a properly spaced start. The same holds for the tied-low chip-select mode, and for dropped requests leaving no trace on later outputs. A cycle-accurate reference model covers these under random control patterns and directed sequences.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  // Strobes passed from the control FSM to the datapath each cycle.
  typedef struct packed {
    logic captureSample;  // conversion begins this edge: hold the sample
    logic commitResult;   // conversion ends this edge: publish the result
    logic driveEn;        // registered bus enable
  } ctlStrobes_t;

endpackage

// File: rtl/adc_bus_ctl.sv
module adc_bus_ctl
  import adc_bus_pkg::*;
#(
  parameter int CONV_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rcN,
  output ctlStrobes_t strb,
  output logic        convIdle,
  output logic        noAcq
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             justDone;
  logic             oeReg;
  logic             startNow;
  logic             finishNow;

  assign startNow  = convIdle && !csN && !rcN;
  assign finishNow = !convIdle && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convIdle <= 1'b1;
      cnt      <= '0;
      justDone <= 1'b0;
      noAcq    <= 1'b0;
      oeReg    <= 1'b0;
    end else begin
      justDone <= finishNow;
      oeReg    <= !csN && rcN;
      if (startNow) begin
        convIdle <= 1'b0;
        cnt      <= CNT_LOAD;
        noAcq    <= justDone;
      end else if (finishNow) begin
        convIdle <= 1'b1;
      end else if (!convIdle) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb.captureSample = startNow;
    strb.commitResult  = finishNow;
    strb.driveEn       = oeReg;
  end

  // Busy-length monitor for R3
  logic [CNT_W:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN)          busyLen <= '0;
    else if (convIdle)  busyLen <= '0;
    else                busyLen <= busyLen + 1'b1;
  end

  a_r1_start_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convIdle) |-> $past(!csN && !rcN));

  a_r2_cs_high_disables: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !strb.driveEn);

  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convIdle) |-> (busyLen == (CNT_W+1)'(CONV_CYCLES)));

  a_r7_bus_off_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convIdle) |-> !strb.driveEn);

  a_r8_flag_with_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noAcq) |-> $fell(convIdle));

endmodule

// File: rtl/adc_bus_dp.sv
module adc_bus_dp
  import adc_bus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [DATA_W-1:0] sampleHold;
  logic [DATA_W-1:0] resultReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleHold <= '0;
      resultReg  <= '0;
    end else begin
      if (strb.captureSample) sampleHold <= sample;
      if (strb.commitResult)  resultReg  <= sampleHold;
    end
  end

  assign dataOe  = strb.driveEn;
  assign dataOut = strb.driveEn ? resultReg : '0;

  a_r4_commit_only_on_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultReg) |-> $past(strb.commitResult));

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rcN,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              convIdle,
  output logic              noAcq
);

  ctlStrobes_t strb;

  adc_bus_ctl #(.CONV_CYCLES(CONV_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN),
    .strb(strb), .convIdle(convIdle), .noAcq(noAcq)
  );

  adc_bus_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sample(sample),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  a_r6_read_stable_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe) && !convIdle && $past(!convIdle)) |-> $stable(dataOut));

endmodule

// File: tb/adc_bus_ctrl_bench.sv
`timescale 1ns/1ps
module adc_bus_ctrl_bench;

  localparam int DW = 16;
  localparam int K  = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic          rcN = 1'b1;
  logic [DW-1:0] sample = '0;
  logic [DW-1:0] dataOut;
  logic          dataOe, convIdle, noAcq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  adc_bus_ctrl #(.DATA_W(DW), .CONV_CYCLES(K)) u_adc_bus_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN), .sample(sample),
    .dataOut(dataOut), .dataOe(dataOe), .convIdle(convIdle), .noAcq(noAcq)
  );

  // Reference model built from the requirements
  logic          mIdle, mJust, mOe, mFlag;
  int            mCnt;
  logic [DW-1:0] mHold, mResult;

  always @(posedge clk) begin
    if (!rstN) begin
      mIdle <= 1'b1; mJust <= 1'b0; mOe <= 1'b0; mFlag <= 1'b0;
      mCnt <= 0; mHold <= '0; mResult <= '0;
    end else begin
      mJust <= !mIdle && (mCnt == 0);
      mOe   <= !csN && rcN;
      if (mIdle && !csN && !rcN) begin
        mIdle <= 1'b0; mCnt <= K - 1; mHold <= sample; mFlag <= mJust;
      end else if (!mIdle && mCnt == 0) begin
        mIdle <= 1'b1; mResult <= mHold;
      end else if (!mIdle) begin
        mCnt <= mCnt - 1;
      end
    end
  end

  function automatic logic [DW-1:0] expBus(input logic oe, input logic [DW-1:0] r);
    return oe ? r : '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R3 convIdle", DW'(convIdle), DW'(mIdle));
    check("R5 dataOe", DW'(dataOe), DW'(mOe));
    check("R4/R6 dataOut", dataOut, expBus(mOe, mResult));
    check("R8 noAcq", DW'(noAcq), DW'(mFlag));
  endtask

  // One cycle: compare at negedge, then drive new inputs
  task automatic tick(input logic cs, input logic rc, input logic [DW-1:0] smp);
    @(negedge clk);
    compareAll();
    csN = cs; rcN = rc; sample = smp;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 idle", DW'(convIdle), DW'(1));
    check("R10 oe", DW'(dataOe), DW'(0));
    check("R10 bus", dataOut, '0);
    check("R10 flag", DW'(noAcq), DW'(0));

    // R2: chip select high blocks conversion
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 16'h1111);
    @(negedge clk);
    check("R2 no start", DW'(convIdle), DW'(1));
    check("R2 oe off", DW'(dataOe), DW'(0));

    // R1: rcN low first, then csN falls and initiates
    tick(1'b1, 1'b0, 16'hA5A5);
    tick(1'b0, 1'b0, 16'hA5A5);
    @(negedge clk);
    check("R1 started", DW'(convIdle), DW'(0));
    check("R7 oe off first busy", DW'(dataOe), DW'(0));
    // R3: requests during busy ignored; read shows previous result (R6)
    tick(1'b0, 1'b1, 16'h0BAD);
    tick(1'b0, 1'b0, 16'h0BAD);
    tick(1'b0, 1'b1, 16'h0BAD);
    @(negedge clk);
    check("R6 previous result", dataOut, 16'h0000);
    check("R9 bus on with cs low rc high", DW'(dataOe), DW'(1));
    for (int i = 0; i < K; i++) tick(1'b0, 1'b1, 16'h0BAD);
    @(negedge clk);
    check("R4 new result", dataOut, 16'hA5A5);

    // R8: hold request low across the end of a conversion
    tick(1'b0, 1'b0, 16'h1234);
    for (int i = 0; i < K + 1; i++) tick(1'b0, 1'b0, 16'h5678);
    @(negedge clk);
    check("R8 restart flagged", DW'(noAcq), DW'(1));
    check("R8 restart busy", DW'(convIdle), DW'(0));
    for (int i = 0; i < K + 3; i++) tick(1'b0, 1'b1, 16'h0);
    tick(1'b0, 1'b0, 16'h9ABC);
    tick(1'b0, 1'b1, 16'h0);
    @(negedge clk);
    check("R8 spaced start clears", DW'(noAcq), DW'(0));

    // Random control patterns against the model
    for (int i = 0; i < 4000; i++) begin
      int mode = $urandom_range(0, 9);
      logic cs, rc;
      if (i % 1000 < 200) cs = 1'b0;  // R9 tied-low chip select phase
      else cs = (mode < 2);
      rc = (mode >= 5);
      tick(cs, rc, DW'($urandom));
    end
    tick(1'b1, 1'b1, '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule